// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block drives the bus, one cycle at a time, for two CPU exception sequences of a small 8-bit core with a 16-bit address space. On an entry request it runs one idle read cycle and then writes the return address and the working registers to a stack that grows downward. It then sets the interrupt mask and reads a two-byte vector. It ends by starting the opcode fetch at the address the vector holds. On a return request it reads the saved bytes back, one per cycle, in the opposite order. It then restores the registers and fetches the opcode and operand at the restored address.

The core's register file stays outside the block. The block samples A, X, CCR, SP and PC when it accepts a request, and it sends updates back as data/write-enable pairs. Each register is written on the clock edge that ends the cycle in which its enable is high. Instruction decode and the choice between pending interrupts belong to the surrounding core.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy` is 0, `rw` is 1 (read), and all five register write-enables are 0.
- R2: The first cycle of entry is a read cycle at the address equal to the SP sampled at acceptance (SP0). No stack write happens in that cycle.
- R3: Entry cycles 1 to 5 are write cycles (`rw`=0). They place PC[7:0] at SP0, PC[15:8] at SP0-1, X at SP0-2, A at SP0-3 and CCR at SP0-4. `rw` is 0 in no other cycle of either sequence.
- R4: In each entry write cycle, SP is written with the write address minus 1, so SP ends at SP0-5.
- R5: The CCR byte that goes to the stack is the value from before the mask is set. In the same cycle, CCR is written with that value plus the mask bit (bit 3 by default) set to 1.
- R6: Entry cycles 6 and 7 read the vector high byte at the request's vector address V and the low byte at V+1. Cycle 8 is a read at the address {high,low}. PC is written with that address at the end of cycle 7. `busy` is 1 for exactly 9 cycles.
- R7: A return reads from SP+1 through SP+5, in rising order, into CCR, A, X, PC[15:8] and PC[7:0]. SP is written with the read address in each of those cycles. The CCR byte read from the stack replaces the mask bit that entry set.
- R8: After the five stack reads, a return reads at the restored PC and then at PC+1. `busy` is 1 for exactly 7 cycles.
- R9: If an entry request and a return request arrive in the same idle cycle, the entry is carried out and the return request is dropped.
- R10: Requests raised while `busy` is 1 are ignored. The running sequence keeps its timing, and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_req | input | 1 | Request to start interrupt entry |
| entry_vec | input | 16 | Address of the vector high byte |
| rti_req | input | 1 | Request to start return-from-interrupt |
| busy | output | 1 | A sequence is in progress |
| addr | output | 16 | Bus address |
| dout | output | 8 | Bus write data |
| din | input | 8 | Bus read data |
| rw | output | 1 | 1 = read, 0 = write |
| a_in | input | 8 | Current A |
| x_in | input | 8 | Current X |
| ccr_in | input | 8 | Current CCR |
| sp_in | input | 16 | Current SP |
| pc_in | input | 16 | Current PC (the return address) |
| a_we | output | 1 | Write enable for A |
| a_d | output | 8 | New A |
| x_we | output | 1 | Write enable for X |
| x_d | output | 8 | New X |
| ccr_we | output | 1 | Write enable for CCR |
| ccr_d | output | 8 | New CCR |
| sp_we | output | 1 | Write enable for SP |
| sp_d | output | 16 | New SP |
| pc_we | output | 1 | Write enable for PC |
| pc_d | output | 16 | New PC |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an entry request and a return request in the same idle cycle. The bench raises both together and requires that cycle 1 is a stack write at SP0, which only entry produces. The second pair is a new request while a sequence is in its push phase. The bench raises both requests in the middle of an entry and then checks two things. Every remaining cycle must match the undisturbed entry, and `busy` must be low in the cycle after that entry ends. The bench sweeps a grid of stack pointers, vectors, return addresses and CCR values with the mask set or clear, and each entry is followed by a return that must restore every register.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [4:0] {
    S_IDLE,
    S_E_DUM, S_E_PCL, S_E_PCH, S_E_X, S_E_A, S_E_CCR,
    S_E_VH, S_E_VL, S_E_FET,
    S_R_CCR, S_R_A, S_R_X, S_R_PCH, S_R_PCL,
    S_R_OP0, S_R_OP1
  } seq_state_e;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_req,
  input  logic       rti_req,
  output seq_state_e state,
  output logic       acc_entry,
  output logic       acc_rti,
  output logic       busy
);
  seq_state_e nxt;

  // Entry has priority over return when both arrive in the same idle cycle.
  assign acc_entry = (state == S_IDLE) && entry_req;
  assign acc_rti   = (state == S_IDLE) && !entry_req && rti_req;
  assign busy      = (state != S_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (acc_entry) nxt = S_E_DUM; else if (acc_rti) nxt = S_R_CCR;
      S_E_DUM: nxt = S_E_PCL;
      S_E_PCL: nxt = S_E_PCH;
      S_E_PCH: nxt = S_E_X;
      S_E_X:   nxt = S_E_A;
      S_E_A:   nxt = S_E_CCR;
      S_E_CCR: nxt = S_E_VH;
      S_E_VH:  nxt = S_E_VL;
      S_E_VL:  nxt = S_E_FET;
      S_E_FET: nxt = S_IDLE;
      S_R_CCR: nxt = S_R_A;
      S_R_A:   nxt = S_R_X;
      S_R_X:   nxt = S_R_PCH;
      S_R_PCH: nxt = S_R_PCL;
      S_R_PCL: nxt = S_R_OP0;
      S_R_OP0: nxt = S_R_OP1;
      S_R_OP1: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/irq_seq_dpath.sv
module irq_seq_dpath
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned I_BIT  = 3,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic              acc_entry,
  input  logic              acc_rti,
  input  logic [ADDR_W-1:0] entry_vec,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              rw,
  output logic              a_we,
  output logic [DATA_W-1:0] a_d,
  output logic              x_we,
  output logic [DATA_W-1:0] x_d,
  output logic              ccr_we,
  output logic [DATA_W-1:0] ccr_d,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_d,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_d
);
  localparam logic [DATA_W-1:0] MASK_BIT = DATA_W'(1) << I_BIT;

  // Address arithmetic kept in functions so the bench can restate it.
  function automatic logic [ADDR_W-1:0] push_next(input logic [ADDR_W-1:0] sp);
    return sp - ADDR_W'(1);
  endfunction
  function automatic logic [ADDR_W-1:0] pull_addr(input logic [ADDR_W-1:0] sp);
    return sp + ADDR_W'(1);
  endfunction
  function automatic logic [ADDR_W-1:0] join_bytes(input logic [DATA_W-1:0] hi,
                                                   input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [ADDR_W-1:0] pc_c, sp_w, vec_c;
  logic [DATA_W-1:0] a_c, x_c, ccr_c, hi_c, lo_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_c <= '0; sp_w <= '0; vec_c <= '0;
      a_c <= '0; x_c <= '0; ccr_c <= '0; hi_c <= '0; lo_c <= '0;
    end else begin
      if (acc_entry) begin
        pc_c <= pc_in; sp_w <= sp_in; vec_c <= entry_vec;
        a_c <= a_in; x_c <= x_in; ccr_c <= ccr_in;
      end else if (acc_rti) begin
        sp_w <= sp_in;
      end else if (sp_we) begin
        sp_w <= sp_d;
      end
      if (state == S_E_VH || state == S_R_PCH) hi_c <= din;
      if (state == S_E_VL || state == S_R_PCL) lo_c <= din;
    end
  end

  always_comb begin
    addr = '0; dout = '0; rw = 1'b1;
    a_we = 1'b0; x_we = 1'b0; ccr_we = 1'b0; sp_we = 1'b0; pc_we = 1'b0;
    a_d = din; x_d = din; ccr_d = din; sp_d = sp_w; pc_d = join_bytes(hi_c, din);
    unique case (state)
      S_E_DUM: addr = sp_w;
      S_E_PCL, S_E_PCH, S_E_X, S_E_A, S_E_CCR: begin
        addr = sp_w; rw = 1'b0;
        sp_we = 1'b1; sp_d = push_next(sp_w);
        unique case (state)
          S_E_PCL: dout = pc_c[DATA_W-1:0];
          S_E_PCH: dout = pc_c[ADDR_W-1:DATA_W];
          S_E_X:   dout = x_c;
          S_E_A:   dout = a_c;
          default: begin
            dout = ccr_c;
            ccr_we = 1'b1; ccr_d = ccr_c | MASK_BIT;
          end
        endcase
      end
      S_E_VH:  addr = vec_c;
      S_E_VL:  begin addr = vec_c + ADDR_W'(1); pc_we = 1'b1; end
      S_E_FET: addr = join_bytes(hi_c, lo_c);
      S_R_CCR, S_R_A, S_R_X, S_R_PCH, S_R_PCL: begin
        addr = pull_addr(sp_w);
        sp_we = 1'b1; sp_d = pull_addr(sp_w);
        unique case (state)
          S_R_CCR: ccr_we = 1'b1;
          S_R_A:   a_we = 1'b1;
          S_R_X:   x_we = 1'b1;
          S_R_PCL: pc_we = 1'b1;
          default: ;
        endcase
      end
      S_R_OP0: addr = join_bytes(hi_c, lo_c);
      S_R_OP1: addr = join_bytes(hi_c, lo_c) + ADDR_W'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned I_BIT  = 3,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic [ADDR_W-1:0] entry_vec,
  input  logic              rti_req,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  input  logic [DATA_W-1:0] din,
  output logic              rw,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              a_we,
  output logic [DATA_W-1:0] a_d,
  output logic              x_we,
  output logic [DATA_W-1:0] x_d,
  output logic              ccr_we,
  output logic [DATA_W-1:0] ccr_d,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_d,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_d
);
  seq_state_e state;
  logic acc_entry, acc_rti;

  // Named events for the checker.
  logic ev_push, ev_mask, ev_pull;
  assign ev_push = busy && !rw;
  assign ev_mask = ccr_we && !rw;
  assign ev_pull = sp_we && rw;

  irq_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .rti_req(rti_req),
    .state(state), .acc_entry(acc_entry), .acc_rti(acc_rti), .busy(busy)
  );

  irq_seq_dpath #(.DATA_W(DATA_W), .I_BIT(I_BIT)) u_dpath (
    .clk(clk), .rst_n(rst_n), .state(state),
    .acc_entry(acc_entry), .acc_rti(acc_rti), .entry_vec(entry_vec),
    .din(din), .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in),
    .sp_in(sp_in), .pc_in(pc_in),
    .addr(addr), .dout(dout), .rw(rw),
    .a_we(a_we), .a_d(a_d), .x_we(x_we), .x_d(x_d),
    .ccr_we(ccr_we), .ccr_d(ccr_d), .sp_we(sp_we), .sp_d(sp_d),
    .pc_we(pc_we), .pc_d(pc_d)
  );
endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned I_BIT  = 3,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic              sp_we,
  input logic [ADDR_W-1:0] sp_d,
  input logic              pc_we,
  input logic              ccr_we,
  input logic [DATA_W-1:0] ccr_d,
  input logic              ev_push,
  input logic              ev_mask,
  input logic              ev_pull
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rw && !sp_we && !pc_we && !ccr_we));

  p_dummy_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rw) |-> ($past(busy) && $past(rw) && $past(addr) == addr));

  p_write_in_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> busy);

  p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> (sp_we && sp_d == addr - ADDR_W'(1)));

  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mask |-> ccr_d[I_BIT]);

  p_pull_asc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pull && $past(ev_pull)) |-> (addr == $past(addr) + ADDR_W'(1)));
endmodule

bind irq_stack_seq irq_stack_seq_chk #(.DATA_W(DATA_W), .I_BIT(I_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rw(rw), .addr(addr),
  .sp_we(sp_we), .sp_d(sp_d), .pc_we(pc_we), .ccr_we(ccr_we), .ccr_d(ccr_d),
  .ev_push(ev_push), .ev_mask(ev_mask), .ev_pull(ev_pull)
);

// File: tb/irq_stack_seq_bench.sv
`timescale 1ns/1ps
module irq_stack_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        entry_req = 1'b0, rti_req = 1'b0;
  logic [15:0] entry_vec = '0;
  logic        busy, rw;
  logic [15:0] addr;
  logic [7:0]  dout, din;
  logic        a_we, x_we, ccr_we, sp_we, pc_we;
  logic [7:0]  a_d, x_d, ccr_d;
  logic [15:0] sp_d, pc_d;

  // Bench register file and stack memory (page 0 only); page FF holds vectors.
  logic [7:0]  ra, rx, rccr;
  logic [15:0] rsp, rpc;
  logic        ld = 1'b0;
  logic [7:0]  ld_a, ld_x, ld_ccr;
  logic [15:0] ld_sp, ld_pc;
  logic [7:0]  mem [256];

  function automatic logic [7:0] vec_byte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign din = (addr[15:8] == 8'hFF) ? vec_byte(addr) : mem[addr[7:0]];

  always @(posedge clk) begin
    if (!rw) mem[addr[7:0]] <= dout;
    if (ld) begin
      ra <= ld_a; rx <= ld_x; rccr <= ld_ccr; rsp <= ld_sp; rpc <= ld_pc;
    end else begin
      if (a_we) ra <= a_d;
      if (x_we) rx <= x_d;
      if (ccr_we) rccr <= ccr_d;
      if (sp_we) rsp <= sp_d;
      if (pc_we) rpc <= pc_d;
    end
  end

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_vec(entry_vec),
    .rti_req(rti_req), .busy(busy), .addr(addr), .dout(dout), .din(din), .rw(rw),
    .a_in(ra), .x_in(rx), .ccr_in(rccr), .sp_in(rsp), .pc_in(rpc),
    .a_we(a_we), .a_d(a_d), .x_we(x_we), .x_d(x_d), .ccr_we(ccr_we), .ccr_d(ccr_d),
    .sp_we(sp_we), .sp_d(sp_d), .pc_we(pc_we), .pc_d(pc_d)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] x, input logic [7:0] c,
                         input logic [15:0] sp, input logic [15:0] pc);
    @(negedge clk);
    ld = 1'b1; ld_a = a; ld_x = x; ld_ccr = c; ld_sp = sp; ld_pc = pc;
    @(negedge clk);
    ld = 1'b0;
  endtask

  // Runs one entry; 'both' also raises the return request (R9), 'poke'
  // raises both requests again mid-sequence (R10).
  task automatic run_entry(input logic [15:0] vec, input bit both, input bit poke);
    logic [15:0] sp0, pc0, tgt;
    logic [7:0]  a0, x0, c0;
    logic [7:0]  pushed [5];
    sp0 = rsp; pc0 = rpc; a0 = ra; x0 = rx; c0 = rccr;
    pushed[0] = pc0[7:0]; pushed[1] = pc0[15:8]; pushed[2] = x0; pushed[3] = a0; pushed[4] = c0;
    tgt = {vec_byte(vec), vec_byte(vec + 16'd1)};
    entry_req = 1'b1; entry_vec = vec; rti_req = both;
    @(negedge clk);
    entry_req = 1'b0; rti_req = 1'b0;
    for (int k = 0; k < 9; k++) begin
      chk(busy == 1'b1, "R6 busy during entry", busy, 1);
      if (k == 0) begin
        chk(rw == 1'b1 && addr == sp0, "R2 dummy read at SP", {rw, addr}, {1'b1, sp0});
      end else if (k <= 5) begin
        chk(rw == 1'b0 && addr == sp0 - 16'(k - 1), "R3 push address", {rw, addr},
            {1'b0, sp0 - 16'(k - 1)});
        chk(dout == pushed[k-1], "R3 push data", dout, pushed[k-1]);
        chk(sp_we && sp_d == sp0 - 16'(k), "R4 SP decrement", sp_d, sp0 - 16'(k));
        if (k == 5)
          chk(ccr_we && ccr_d == (c0 | 8'h08), "R5 mask set", ccr_d, c0 | 8'h08);
        if (k == 3 && poke) begin entry_req = 1'b1; rti_req = 1'b1; end
        if (k == 4) begin entry_req = 1'b0; rti_req = 1'b0; end
      end else begin
        logic [15:0] ea;
        ea = (k == 6) ? vec : (k == 7) ? vec + 16'd1 : tgt;
        chk(rw == 1'b1 && addr == ea, "R6 vector/fetch address", addr, ea);
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, "R6/R10 idle after 9 cycles", busy, 0);
    chk(rsp == sp0 - 16'd5, "R4 SP final", rsp, sp0 - 16'd5);
    chk(rpc == tgt, "R6 PC target", rpc, tgt);
    chk(rccr == (c0 | 8'h08), "R5 CCR masked", rccr, c0 | 8'h08);
  endtask

  task automatic run_rti(input logic [15:0] sp0, input logic [15:0] pc0, input logic [7:0] a0,
                         input logic [7:0] x0, input logic [7:0] c0);
    logic [15:0] s;
    s = rsp;
    rti_req = 1'b1;
    @(negedge clk);
    rti_req = 1'b0;
    for (int k = 0; k < 7; k++) begin
      logic [15:0] ea;
      ea = (k < 5) ? s + 16'(k + 1) : pc0 + 16'(k - 5);
      chk(busy == 1'b1, "R8 busy during return", busy, 1);
      chk(rw == 1'b1 && addr == ea, (k < 5) ? "R7 pull address" : "R8 opcode fetch address",
          {rw, addr}, {1'b1, ea});
      @(negedge clk);
    end
    chk(busy == 1'b0, "R8 idle after 7 cycles", busy, 0);
    chk(rsp == sp0, "R7 SP restored", rsp, sp0);
    chk(rpc == pc0, "R7 PC restored", rpc, pc0);
    chk({ra, rx} == {a0, x0}, "R7 A/X restored", {ra, rx}, {a0, x0});
    chk(rccr == c0, "R7 CCR replaces mask", rccr, c0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && rw == 1'b1, "R1 reset idle", {busy, rw}, 2'b01);
    chk(!(a_we | x_we | ccr_we | sp_we | pc_we), "R1 reset no writes",
        {a_we, x_we, ccr_we, sp_we, pc_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int si = 0; si < 6; si++) begin
      for (int vi = 0; vi < 4; vi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [15:0] sp0, pc0;
          logic [7:0]  a0, x0, c0;
          sp0 = 16'h0020 + 16'(si * 37);
          pc0 = 16'h8000 + 16'(si * 16'h0123 + vi * 16'h0411);
          a0 = 8'(si * 29 + vi); x0 = 8'(vi * 53 + ci); c0 = 8'(ci ? 8'h08 : 8'h00) | 8'(si + vi * 16) & 8'hF7;
          preload(a0, x0, c0, sp0, pc0);
          run_entry(16'hFFF0 - 16'(vi * 4), (si == 1), (si == 2));
          chk(!busy && rw, "R1 idle between sequences", {busy, rw}, 2'b01);
          run_rti(sp0, pc0, a0, x0, c0);
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule